// File: doc/BRIEF.md
# Serial DAC Frame Receiver

This block is the digital front end of a 16-bit voltage-output digital-to-analog converter. A host writes to it over a three-wire serial slave link made of an active-low frame select, a serial clock and a data line. Each write is a fixed 24-bit word, sent most significant bit first. The receiver keeps a 16-bit straight-binary output code and a 2-bit power mode. Both are registered and feed a model of the analog stage and its output switch network.

All logic runs on one system clock. The three serial inputs are sampled on that clock, and falling edges of the frame select and of the serial clock are detected from the samples. The serial inputs are expected to be synchronous to the system clock, or already brought into its domain. A frame is applied only when it completes: the 24th falling serial clock edge loads the code and the mode together and raises a one-cycle update strobe. A frame that ends early leaves every output as it was. A decoded four-way output select tells the analog model whether the amplifier drives the pin, or whether the pin is tied to ground through about 1 kΩ, tied to ground through about 100 kΩ, or left open.

Top module: `serial_dac_rx`

## Requirements
- R1: While reset is held and after it is released, dac_code is 0, pwr_mode is 2'b00 (normal), out_sel is 4'b0001 (amplifier) and update stays low until the first complete frame.
- R2: A frame opens only on a high-to-low transition of sync_n. While it is open, sdin is sampled on each falling edge of sclk and shifted in with the most significant bit first.
- R3: Frame bit positions, counted from 23 (first sent) down to 0: bits 23 to 18 have no effect, bits 17:16 are the power mode and bits 15:0 are the output code.
- R4: The 24th falling sclk edge of an open frame updates dac_code and pwr_mode together, and update is high for that same clock.
- R5: If sync_n goes high before the 24th falling edge, the frame is dropped: dac_code, pwr_mode and out_sel keep their values and update stays low. Bits of the dropped frame do not reach the next frame.
- R6: The power mode is encoded as 00 normal, 01 tied to ground through 1 kΩ, 10 tied to ground through 100 kΩ and 11 open. out_sel is one-hot: bit 0 amplifier, bit 1 1 kΩ, bit 2 100 kΩ, bit 3 open. It changes together with pwr_mode.
- R7: A frame that selects a power-down mode still loads its code field. dac_code then holds that value for as long as power-down lasts, until the next complete frame.
- R8: Falling sclk edges after the 24th, while sync_n stays low, are ignored. They cause no second update.
- R9: After a completed frame, no further frame is accepted until sync_n has gone high and then fallen again.
- R10: update is never high for two clocks in a row, and dac_code and pwr_mode change only in a clock where update is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdin | input | 1 | Serial data, most significant bit first |
| dac_code | output | 16 | Registered output code |
| pwr_mode | output | 2 | Registered power mode |
| out_sel | output | 4 | One-hot output select for the analog model |
| update | output | 1 | One-clock strobe on each commit |

## Verification
Complete frames are sent with distinct code values and with the ignored top bits set to all ones and to all zeros. These show that the code field comes from the right positions and in the right order, and that the ignored bits are really dropped. Every power mode is written with a non-zero code, which separates a mode decode fault from a code that is lost during power-down. Frames cut off after 20 and after 23 bits, each followed by a clean frame, distinguish a commit that comes too early from bits that leak from one frame into the next. Extra clock edges sent after a completed frame, with the frame select kept low, show whether the receiver wrongly starts a second frame or commits a second time.

// File: rtl/dac_rx_pkg.sv
package dac_rx_pkg;
  localparam int CODE_W = 16;
  localparam int MODE_W = 2;
  localparam int PAD_W  = 6;
  localparam int SEL_W  = 1 << MODE_W;

  typedef enum logic [MODE_W-1:0] {
    PM_NORMAL = 2'b00,
    PM_R1K    = 2'b01,
    PM_R100K  = 2'b10,
    PM_OPEN   = 2'b11
  } pwr_mode_e;
endpackage

// File: rtl/dac_rx_edges.sv
module dac_rx_edges (
  input  logic clk,
  input  logic rst,
  input  logic sync_n,
  input  logic sclk,
  input  logic sdin,
  output logic sync_hi,
  output logic sync_fall,
  output logic sclk_fall,
  output logic din_s
);
  logic s1_sync, s2_sync, s1_sclk, s2_sclk, s1_din;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_sync <= 1'b1;
      s2_sync <= 1'b1;
      s1_sclk <= 1'b1;
      s2_sclk <= 1'b1;
      s1_din  <= 1'b0;
    end else begin
      s1_sync <= sync_n;
      s2_sync <= s1_sync;
      s1_sclk <= sclk;
      s2_sclk <= s1_sclk;
      s1_din  <= sdin;
    end
  end

  assign sync_hi   = s1_sync;
  assign sync_fall = s2_sync & ~s1_sync;
  assign sclk_fall = s2_sclk & ~s1_sclk;
  assign din_s     = s1_din;
endmodule

// File: rtl/dac_rx_frame.sv
module dac_rx_frame #(
  parameter int FRAME_W = 24,
  parameter int PAY_W   = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_hi,
  input  logic             sync_fall,
  input  logic             sclk_fall,
  input  logic             din_s,
  output logic             done,
  output logic [PAY_W-1:0] payload
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [PAY_W-2:0] shift_q;
  logic [CNT_W-1:0] cnt_q;
  logic             open_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
      cnt_q   <= '0;
      open_q  <= 1'b0;
      done    <= 1'b0;
      payload <= '0;
    end else begin
      done <= 1'b0;
      if (sync_hi) begin
        shift_q <= '0;
        cnt_q   <= '0;
        open_q  <= 1'b0;
      end else if (sync_fall) begin
        shift_q <= '0;
        cnt_q   <= '0;
        open_q  <= 1'b1;
      end else if (open_q && sclk_fall) begin
        if (PAY_W > 2) shift_q <= {shift_q[PAY_W-3:0], din_s};
        else           shift_q <= din_s;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          done    <= 1'b1;
          open_q  <= 1'b0;
          payload <= {shift_q, din_s};
        end
      end
    end
  end
endmodule

// File: rtl/dac_rx_commit.sv
module dac_rx_commit
  import dac_rx_pkg::*;
#(
  parameter int C_W = CODE_W,
  parameter int M_W = MODE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done,
  input  logic [C_W+M_W-1:0] payload,
  output logic [C_W-1:0]   code,
  output logic [M_W-1:0]   mode,
  output logic [(1<<M_W)-1:0] sel,
  output logic             strobe
);
  localparam int S_W = 1 << M_W;

  logic [M_W-1:0] new_mode;
  logic [S_W-1:0] new_sel;

  assign new_mode = payload[C_W +: M_W];

  for (genvar i = 0; i < S_W; i++) begin : g_dec
    assign new_sel[i] = (new_mode == M_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code   <= '0;
      mode   <= '0;
      sel    <= S_W'(1);
      strobe <= 1'b0;
    end else begin
      strobe <= done;
      if (done) begin
        code <= payload[C_W-1:0];
        mode <= new_mode;
        sel  <= new_sel;
      end
    end
  end
endmodule

// File: rtl/serial_dac_rx.sv
module serial_dac_rx
  import dac_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_n,
  input  logic              sclk,
  input  logic              sdin,
  output logic [CODE_W-1:0] dac_code,
  output logic [MODE_W-1:0] pwr_mode,
  output logic [SEL_W-1:0]  out_sel,
  output logic              update
);
  localparam int PAY_W   = CODE_W + MODE_W;
  localparam int FRAME_W = PAY_W + PAD_W;

  logic             sync_hi, sync_fall, sclk_fall, din_s, done;
  logic [PAY_W-1:0] payload;

  dac_rx_edges u_edges (
    .clk(clk), .rst(rst), .sync_n(sync_n), .sclk(sclk), .sdin(sdin),
    .sync_hi(sync_hi), .sync_fall(sync_fall), .sclk_fall(sclk_fall), .din_s(din_s)
  );

  dac_rx_frame #(.FRAME_W(FRAME_W), .PAY_W(PAY_W)) u_frame (
    .clk(clk), .rst(rst), .sync_hi(sync_hi), .sync_fall(sync_fall),
    .sclk_fall(sclk_fall), .din_s(din_s), .done(done), .payload(payload)
  );

  dac_rx_commit #(.C_W(CODE_W), .M_W(MODE_W)) u_commit (
    .clk(clk), .rst(rst), .done(done), .payload(payload),
    .code(dac_code), .mode(pwr_mode), .sel(out_sel), .strobe(update)
  );
endmodule

// File: rtl/serial_dac_rx_chk.sv
module serial_dac_rx_chk
  import dac_rx_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              sync_n,
  input logic [CODE_W-1:0] dac_code,
  input logic [MODE_W-1:0] pwr_mode,
  input logic [SEL_W-1:0]  out_sel,
  input logic              update
);
  p_strobe_single_r10: assert property (@(posedge clk) disable iff (rst)
    update |=> !update);

  p_code_moves_on_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_code) |-> update);

  p_mode_moves_on_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(pwr_mode) |-> update);

  p_sel_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $countones(out_sel) == 1);

  p_sel_tracks_mode_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_sel) |-> update);

  p_idle_no_commit_r5: assert property (@(posedge clk) disable iff (rst)
    (sync_n && $past(sync_n) && $past(sync_n, 2) && $past(sync_n, 3)) |-> !update);
endmodule

bind serial_dac_rx serial_dac_rx_chk u_chk (
  .clk(clk), .rst(rst), .sync_n(sync_n), .dac_code(dac_code),
  .pwr_mode(pwr_mode), .out_sel(out_sel), .update(update)
);

// File: tb/sim_serial_dac_rx.sv
`timescale 1ns/1ps
module sim_serial_dac_rx;
  logic clk = 1'b0, rst = 1'b1, sync_n = 1'b1, sclk = 1'b0, sdin = 1'b0;
  logic [15:0] dac_code;
  logic [1:0]  pwr_mode;
  logic [3:0]  out_sel;
  logic        update;
  int checks = 0, errors = 0, n_upd = 0, run = 0, max_run = 0;

  always #10 clk = ~clk;

  serial_dac_rx u0 (
    .clk(clk), .rst(rst), .sync_n(sync_n), .sclk(sclk), .sdin(sdin),
    .dac_code(dac_code), .pwr_mode(pwr_mode), .out_sel(out_sel), .update(update)
  );

  always @(posedge clk) begin
    if (rst) begin
      run = 0;
    end else if (update) begin
      n_upd++;
      run++;
      if (run > max_run) max_run = run;
    end else begin
      run = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_frame();
    sync_n = 1'b0;
    wclk(3);
  endtask

  task automatic close_frame();
    sync_n = 1'b1;
    wclk(4);
  endtask

  task automatic send_bits(input logic [23:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      sdin = w[23 - (i % 24)];
      sclk = 1'b1;
      wclk(3);
      sclk = 1'b0;
      wclk(3);
    end
  endtask

  task automatic full_frame(input logic [23:0] w);
    open_frame();
    send_bits(w, 24);
    wclk(4);
    close_frame();
  endtask

  function automatic logic [3:0] sel_of(input logic [1:0] m);
    return 4'b0001 << m;
  endfunction

  task automatic expect_state(input string tag, input logic [15:0] c, input logic [1:0] m);
    chk(dac_code == c, tag, dac_code, c);
    chk(pwr_mode == m, tag, pwr_mode, m);
    chk(out_sel == sel_of(m), tag, out_sel, sel_of(m));
  endtask

  task automatic t_reset();
    expect_state("R1 reset", 16'h0000, 2'b00);
    chk(n_upd == 0, "R1 no strobe", n_upd, 0);
  endtask

  task automatic t_basic();
    int u0c = n_upd;
    full_frame(24'h00_1234);
    expect_state("R2 R4 basic", 16'h1234, 2'b00);
    chk(n_upd == u0c + 1, "R4 one strobe", n_upd, u0c + 1);
    full_frame(24'hFC_ABCD);
    expect_state("R3 pad ones ignored", 16'hABCD, 2'b00);
    full_frame(24'h03_8001);
    expect_state("R2 msb first", 16'h8001, 2'b11);
  endtask

  task automatic t_modes();
    for (int m = 0; m < 4; m++) begin
      logic [15:0] c = 16'h5A00 + 16'(m);
      full_frame({6'b101010, 2'(m), c});
      expect_state("R6 R7 mode", c, 2'(m));
    end
    full_frame({6'h00, 2'b01, 16'hBEEF});
    wclk(20);
    expect_state("R7 code held in power-down", 16'hBEEF, 2'b01);
  endtask

  task automatic t_abort();
    int u0c;
    full_frame(24'h00_4321);
    u0c = n_upd;
    open_frame();
    send_bits(24'h02_FFFF, 20);
    close_frame();
    expect_state("R5 abort 20", 16'h4321, 2'b00);
    open_frame();
    send_bits(24'h03_7777, 23);
    close_frame();
    expect_state("R5 abort 23", 16'h4321, 2'b00);
    chk(n_upd == u0c, "R5 no strobe", n_upd, u0c);
    full_frame(24'h01_0F0F);
    expect_state("R5 clean after abort", 16'h0F0F, 2'b01);
  endtask

  task automatic t_extra();
    int u0c = n_upd;
    open_frame();
    send_bits(24'h00_C3C3, 24);
    send_bits(24'hFF_FFFF, 8);
    wclk(4);
    expect_state("R8 extra edges", 16'hC3C3, 2'b00);
    chk(n_upd == u0c + 1, "R8 single strobe", n_upd, u0c + 1);
    send_bits(24'h02_1111, 24);
    wclk(4);
    expect_state("R9 no restart", 16'hC3C3, 2'b00);
    chk(n_upd == u0c + 1, "R9 no strobe", n_upd, u0c + 1);
    close_frame();
    full_frame(24'h02_2222);
    expect_state("R9 after re-select", 16'h2222, 2'b10);
  endtask

  task automatic t_strobe();
    chk(max_run == 1, "R10 strobe width", max_run, 1);
  endtask

  initial begin
    wclk(5);
    t_reset();
    rst = 1'b0;
    wclk(5);
    t_reset();
    t_basic();
    t_modes();
    t_abort();
    t_extra();
    t_strobe();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #3ms;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule